// File: doc/BRIEF.md
# Transmit Ring Index Controller

This block keeps the bookkeeping for a circular transmit queue built from fixed-size buffer slots in a shared message memory, as used by a CAN controller. It holds a read index (the next slot to go out on the bus) and a write index (the next slot the host fills). From the two indices and a registered full flag it derives how many slots are still free. The host starts a send by setting the request bit that belongs to the slot under the write index. The protocol engine reports each completed transmission. The block also lists which slots currently hold a message waiting to be sent.

For any buffer number, the block also gives the word address of that buffer's slot. The address is the configured base plus the buffer number times the slot size in words. The slot size follows a 3-bit payload-size code, so the slot spacing can be set at run time. The ring depth is a run-time input. A mode bit switches the ring off when the buffers are handled as a priority queue elsewhere.

Top module: `tx_ring_index_ctrl`

## Requirements
- R1: After reset, both indices are 0, the free level equals the effective depth, and the full flag, the pending vector and the overflow pulse are all 0.
- R2: Bit n of `add_req_i` is the request for buffer n. An add is recognised only when the bit at the current write index is 1; all other bits are ignored. An accepted add sets pending bit n and moves the write index to the next slot, wrapping to 0 after slot depth-1.
- R3: `tx_done_i` moves the read index forward one slot, wrapping the same way, and clears the pending bit of the slot it leaves. When the ring is empty, `tx_done_i` is ignored.
- R4: `free_o` equals the number of unoccupied slots, from 0 up to the effective depth.
- R5: `full_o` becomes 1 when an add makes the write index equal to the read index. It stays 1, with `free_o` at 0, until a completion moves the read index forward.
- R6: An add request while the ring is full is ignored. The indices and the pending vector do not change, and `ovf_err_o` is 1 for exactly the one cycle after the request.
- R7: An accepted add and an accepted completion in the same cycle move both indices, and the free level stays unchanged.
- R8: When `cfg_queue_mode_i` is 1 (0 selects ring mode), adds and completions are ignored and the indices hold.
- R9: Slots leave the ring in the order they were added: the read index steps through the same sequence of slots that the accepted adds filled.
- R10: `ram_addr_o` equals `cfg_base_i + addr_buf_i * W`. W is the slot size in words given by `cfg_size_code_i`: 0→4, 1→5, 2→6, 3→7, 4→8, 5→10, 6→14, 7→18. These cover 8, 12, 16, 20, 24, 32, 48 and 64 payload bytes.
- R11: The effective depth is `cfg_depth_i` clamped to 1..32. A value of 0 acts as 1, and values above 32 act as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_queue_mode_i | input | 1 | 0 = ring mode, 1 = ring held (queue mode) |
| cfg_depth_i | input | 6 | Requested ring depth |
| cfg_base_i | input | 16 | Word address of buffer 0 |
| cfg_size_code_i | input | 3 | Payload-size code that selects the slot size |
| add_req_i | input | 32 | Per-buffer add-request bits |
| tx_done_i | input | 1 | Transmission of the slot at the read index completed |
| addr_buf_i | input | 5 | Buffer number for the address lookup |
| get_idx_o | output | 5 | Read index |
| put_idx_o | output | 5 | Write index |
| free_o | output | 6 | Free slot count |
| full_o | output | 1 | Ring full |
| pend_o | output | 32 | Slots holding messages waiting to be sent |
| ovf_err_o | output | 1 | One-cycle pulse after a rejected add |
| ram_addr_o | output | 16 | Word address of the slot of `addr_buf_i` |

## Verification
On every cycle, the assertions check how the free level moves: down by one on a lone add, up by one on a lone completion, and unchanged when both happen together. They also check that the number of pending bits always matches the occupied slot count, that the full flag forces a zero free level, that a rejected add freezes the write index and produces the overflow pulse, and that queue mode holds both indices. Only the bench scenarios can show the parts that need a reference model over many cycles. These are the order in which slots leave the ring, wrapping at depths of 1, 4 and 32, the clamping of out-of-range depths, requests on the wrong bit being ignored, and the address value for all eight size codes.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;

  typedef logic [2:0] size_code_t;

  localparam int unsigned SLOT_W = 5;

  // words per slot: two header words plus payload/4
  function automatic logic [SLOT_W-1:0] slot_words(input size_code_t code);
    logic [SLOT_W-1:0] w;
    case (code)
      3'd0: w = 5'd4;
      3'd1: w = 5'd5;
      3'd2: w = 5'd6;
      3'd3: w = 5'd7;
      3'd4: w = 5'd8;
      3'd5: w = 5'd10;
      3'd6: w = 5'd14;
      default: w = 5'd18;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/tx_ring_ptr.sv
module tx_ring_ptr #(
  parameter int IDX_W = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ring_en_i,
  input  logic [CNT_W-1:0] depth_i,
  input  logic             add_hit_i,
  input  logic             done_req_i,
  output logic [IDX_W-1:0] get_o,
  output logic [IDX_W-1:0] put_o,
  output logic             full_o,
  output logic [CNT_W-1:0] free_o,
  output logic             add_acc_o,
  output logic             done_acc_o,
  output logic             ovf_o
);

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i,
                                                 input logic [CNT_W-1:0] d);
    if (CNT_W'(i) + CNT_W'(1) >= d) return '0;
    return i + IDX_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] free_calc(input logic [IDX_W-1:0] g,
                                                  input logic [IDX_W-1:0] p,
                                                  input logic f,
                                                  input logic [CNT_W-1:0] d);
    if (f) return '0;
    if (p >= g) return d - CNT_W'(p - g);
    return CNT_W'(g - p);
  endfunction

  logic [IDX_W-1:0] get_q, put_q, get_d, put_d;
  logic             full_q, full_d, ovf_q;
  logic             empty;

  assign empty      = !full_q && (put_q == get_q);
  assign add_acc_o  = ring_en_i && add_hit_i && !full_q;
  assign done_acc_o = ring_en_i && done_req_i && !empty;

  always_comb begin
    get_d  = get_q;
    put_d  = put_q;
    full_d = full_q;
    if (add_acc_o)  put_d = step_idx(put_q, depth_i);
    if (done_acc_o) get_d = step_idx(get_q, depth_i);
    if (add_acc_o && !done_acc_o && (put_d == get_q)) full_d = 1'b1;
    else if (done_acc_o)                              full_d = 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      get_q  <= '0;
      put_q  <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      get_q  <= get_d;
      put_q  <= put_d;
      full_q <= full_d;
      ovf_q  <= ring_en_i && add_hit_i && full_q;
    end
  end

  assign get_o  = get_q;
  assign put_o  = put_q;
  assign full_o = full_q;
  assign ovf_o  = ovf_q;
  assign free_o = free_calc(get_q, put_q, full_q, depth_i);

endmodule

// File: rtl/tx_ring_pend.sv
module tx_ring_pend #(
  parameter int SLOTS = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  output logic [SLOTS-1:0] pend_o
);

  logic [SLOTS-1:0] pend_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit_set, hit_clr;
    assign hit_set = set_i && (set_idx_i == IDX_W'(s));
    assign hit_clr = clr_i && (clr_idx_i == IDX_W'(s));
    always_ff @(posedge clk_i) begin
      if (!rst_ni)      pend_q[s] <= 1'b0;
      else if (hit_set) pend_q[s] <= 1'b1;
      else if (hit_clr) pend_q[s] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/tx_ring_addr.sv
module tx_ring_addr
  import tx_ring_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  size_code_t        code_i,
  input  logic [IDX_W-1:0]  buf_i,
  output logic [ADDR_W-1:0] addr_o
);

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] b,
                                                   input logic [IDX_W-1:0] n,
                                                   input size_code_t c);
    return b + ADDR_W'(n) * ADDR_W'(slot_words(c));
  endfunction

  assign addr_o = slot_addr(base_i, buf_i, code_i);

endmodule

// File: rtl/tx_ring_index_ctrl.sv
module tx_ring_index_ctrl
  import tx_ring_pkg::*;
#(
  parameter int MAX_DEPTH = 32,
  parameter int ADDR_W    = 16,
  localparam int IDX_W    = $clog2(MAX_DEPTH),
  localparam int CNT_W    = $clog2(MAX_DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_queue_mode_i,
  input  logic [CNT_W-1:0]     cfg_depth_i,
  input  logic [ADDR_W-1:0]    cfg_base_i,
  input  logic [2:0]           cfg_size_code_i,
  input  logic [MAX_DEPTH-1:0] add_req_i,
  input  logic                 tx_done_i,
  input  logic [IDX_W-1:0]     addr_buf_i,
  output logic [IDX_W-1:0]     get_idx_o,
  output logic [IDX_W-1:0]     put_idx_o,
  output logic [CNT_W-1:0]     free_o,
  output logic                 full_o,
  output logic [MAX_DEPTH-1:0] pend_o,
  output logic                 ovf_err_o,
  output logic [ADDR_W-1:0]    ram_addr_o
);

  function automatic logic [CNT_W-1:0] clamp_depth(input logic [CNT_W-1:0] d);
    if (d == '0) return CNT_W'(1);
    if (d > CNT_W'(MAX_DEPTH)) return CNT_W'(MAX_DEPTH);
    return d;
  endfunction

  // named internal events, also seen by the bound checker
  logic [CNT_W-1:0] depth_eff;
  logic             ring_en;
  logic             add_hit;
  logic             add_acc;
  logic             done_acc;

  assign depth_eff = clamp_depth(cfg_depth_i);
  assign ring_en   = !cfg_queue_mode_i;
  assign add_hit   = add_req_i[put_idx_o];

  tx_ring_ptr #(.IDX_W(IDX_W), .CNT_W(CNT_W)) ptr_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ring_en_i  (ring_en),
    .depth_i    (depth_eff),
    .add_hit_i  (add_hit),
    .done_req_i (tx_done_i),
    .get_o      (get_idx_o),
    .put_o      (put_idx_o),
    .full_o     (full_o),
    .free_o     (free_o),
    .add_acc_o  (add_acc),
    .done_acc_o (done_acc),
    .ovf_o      (ovf_err_o)
  );

  tx_ring_pend #(.SLOTS(MAX_DEPTH), .IDX_W(IDX_W)) pend_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (add_acc),
    .set_idx_i (put_idx_o),
    .clr_i     (done_acc),
    .clr_idx_i (get_idx_o),
    .pend_o    (pend_o)
  );

  tx_ring_addr #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) addr_i (
    .base_i (cfg_base_i),
    .code_i (size_code_t'(cfg_size_code_i)),
    .buf_i  (addr_buf_i),
    .addr_o (ram_addr_o)
  );

endmodule

// File: rtl/tx_ring_index_chk.sv
module tx_ring_index_chk #(
  parameter int MAX_DEPTH = 32,
  parameter int IDX_W     = 5,
  parameter int CNT_W     = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ring_en,
  input logic [CNT_W-1:0]     depth_eff,
  input logic                 add_hit,
  input logic                 add_acc,
  input logic                 done_acc,
  input logic                 full_o,
  input logic [CNT_W-1:0]     free_o,
  input logic [IDX_W-1:0]     get_idx_o,
  input logic [IDX_W-1:0]     put_idx_o,
  input logic [MAX_DEPTH-1:0] pend_o,
  input logic                 ovf_err_o
);

  a_r2_add_takes_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_acc && !done_acc |=> free_o == $past(free_o) - 1'b1);

  a_r3_done_frees_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_acc && !add_acc |=> free_o == $past(free_o) + 1'b1);

  a_r4_free_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_o <= depth_eff);

  a_r5_full_no_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> free_o == '0);

  a_r6_reject_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_en && add_hit && full_o |=> ovf_err_o && $stable(put_idx_o));

  a_r6_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_err_o |-> $past(full_o));

  a_r7_both_keep_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_acc && done_acc |=> free_o == $past(free_o));

  a_r8_queue_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ring_en |=> $stable(get_idx_o) && $stable(put_idx_o));

  a_r9_pend_matches_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pend_o) == int'(depth_eff) - int'(free_o));

endmodule

bind tx_ring_index_ctrl tx_ring_index_chk #(
  .MAX_DEPTH(MAX_DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ring_en   (ring_en),
  .depth_eff (depth_eff),
  .add_hit   (add_hit),
  .add_acc   (add_acc),
  .done_acc  (done_acc),
  .full_o    (full_o),
  .free_o    (free_o),
  .get_idx_o (get_idx_o),
  .put_idx_o (put_idx_o),
  .pend_o    (pend_o),
  .ovf_err_o (ovf_err_o)
);

// File: tb/tx_ring_index_ctrl_tb.sv
`timescale 1ns/1ps
module tx_ring_index_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qmode = 1'b0;
  logic [5:0]  depth = 6'd4;
  logic [15:0] base = 16'h0100;
  logic [2:0]  code = 3'd0;
  logic [31:0] add_req = '0;
  logic        tx_done = 1'b0;
  logic [4:0]  abuf = '0;
  logic [4:0]  get_idx, put_idx;
  logic [5:0]  free_lvl;
  logic        full;
  logic [31:0] pend;
  logic        ovf;
  logic [15:0] raddr;

  always #5 clk = ~clk;

  tx_ring_index_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_queue_mode_i(qmode), .cfg_depth_i(depth),
    .cfg_base_i(base), .cfg_size_code_i(code), .add_req_i(add_req),
    .tx_done_i(tx_done), .addr_buf_i(abuf), .get_idx_o(get_idx),
    .put_idx_o(put_idx), .free_o(free_lvl), .full_o(full), .pend_o(pend),
    .ovf_err_o(ovf), .ram_addr_o(raddr)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // reference model
  int mdep, mget, mput, mcnt;
  logic [31:0] mpend;
  int ord [64];
  int oh, ot;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int d);
    @(negedge clk);
    rst_n = 1'b0; depth = 6'(d); add_req = '0; tx_done = 1'b0; qmode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mdep = (d == 0) ? 1 : (d > 32 ? 32 : d);
    mget = 0; mput = 0; mcnt = 0; mpend = '0; oh = 0; ot = 0;
  endtask

  task automatic check_state(input string tag);
    chk({tag, " get"},  get_idx, mget);
    chk({tag, " put"},  put_idx, mput);
    chk({tag, " free"}, free_lvl, mdep - mcnt);
    chk({tag, " full"}, full, (mcnt == mdep) ? 1 : 0);
    chk({tag, " pend"}, pend, mpend);
  endtask

  // one cycle: a = request at put bit, d = completion, noise = other bits
  task automatic step(input bit a, input bit d, input logic [31:0] noise, input string tag);
    bit acc_a, acc_d, exp_ovf;
    logic [31:0] putbit;
    putbit = 32'd1 << mput;
    if (d && mcnt > 0 && !qmode) chk({tag, " R9 order"}, get_idx, ord[oh]);
    add_req = (a ? putbit : 32'd0) | (noise & ~putbit);
    tx_done = d;
    exp_ovf = !qmode && a && (mcnt == mdep);
    acc_a   = !qmode && a && (mcnt < mdep);
    acc_d   = !qmode && d && (mcnt > 0);
    @(negedge clk);
    add_req = '0; tx_done = 1'b0;
    if (acc_a) begin
      mpend[mput] = 1'b1; ord[ot] = mput; ot = (ot + 1) % 64;
      mput = (mput + 1 == mdep) ? 0 : mput + 1; mcnt++;
    end
    if (acc_d) begin
      mpend[mget] = 1'b0; oh = (oh + 1) % 64;
      mget = (mget + 1 == mdep) ? 0 : mget + 1; mcnt--;
    end
    check_state(tag);
    chk({tag, " R6 ovf"}, ovf, exp_ovf);
  endtask

  task automatic t_reset();
    do_reset(4);
    check_state("R1 reset");
    chk("R1 ovf", ovf, 0);
  endtask

  task automatic t_fill_overflow();
    do_reset(4);
    for (int i = 0; i < 4; i++) step(1, 0, '0, "R2 R4 fill");
    chk("R5 full after fill", full, 1);
    step(1, 0, '0, "R6 reject when full");
    step(0, 0, '0, "R6 pulse ends");
    chk("R6 pulse single cycle", ovf, 0);
  endtask

  task automatic t_drain();
    for (int i = 0; i < 4; i++) step(0, 1, '0, "R3 R9 drain");
    chk("R5 full cleared", full, 0);
    step(0, 1, '0, "R3 done on empty ignored");
  endtask

  task automatic t_wrong_bit();
    do_reset(4);
    step(1, 0, '0, "R2 first add");
    step(0, 0, 32'hFFFF_FFFF, "R2 other bits ignored");
    step(1, 0, 32'hA5A5_0000, "R2 add with noise");
  endtask

  task automatic t_simul();
    do_reset(4);
    step(1, 0, '0, "R7 prime");
    step(1, 0, '0, "R7 prime");
    for (int i = 0; i < 9; i++) step(1, 1, '0, "R7 R2 simultaneous wrap");
    step(1, 1, '0, "R7 final");
  endtask

  task automatic t_queue_mode();
    do_reset(4);
    step(1, 0, '0, "R8 pre");
    @(negedge clk); qmode = 1'b1;
    step(1, 0, '0, "R8 add ignored");
    step(0, 1, '0, "R8 done ignored");
    @(negedge clk); qmode = 1'b0;
    step(0, 1, '0, "R8 ring resumes");
  endtask

  task automatic t_depths();
    do_reset(1);
    step(1, 0, '0, "R11 depth1 add");
    chk("R11 depth1 full", full, 1);
    step(1, 0, '0, "R11 depth1 reject");
    step(0, 1, '0, "R11 depth1 done");
    do_reset(0);
    chk("R11 depth0 acts as 1", free_lvl, 1);
    step(1, 0, '0, "R11 depth0 add");
    do_reset(45);
    chk("R11 depth45 acts as 32", free_lvl, 32);
    for (int i = 0; i < 32; i++) step(1, 0, '0, "R11 deep fill");
    step(1, 0, '0, "R11 deep reject");
    for (int i = 0; i < 3; i++) step(0, 1, '0, "R11 deep drain");
    for (int i = 0; i < 3; i++) step(1, 0, '0, "R11 deep wrap refill");
  endtask

  task automatic t_addr();
    int bytes [8] = '{8, 12, 16, 20, 24, 32, 48, 64};
    int idxs  [3] = '{0, 1, 31};
    base = 16'h0240;
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 3; k++) begin
        code = 3'(c); abuf = 5'(idxs[k]);
        #1;
        chk("R10 address", raddr, 16'h0240 + idxs[k] * (bytes[c] / 4 + 2));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_overflow();
    t_drain();
    t_wrong_bit();
    t_simul();
    t_queue_mode();
    t_depths();
    t_addr();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule